// File: doc/BRIEF.md
# First-Level Compressed Prefix Lookup

This block resolves the upper 16 bits of an IPv4 destination address into a 16-bit forwarding pointer. It forms the first level of a compact longest-prefix-match table. The pointer either names a next-hop entry or names a second-level chunk, and a later stage searches that chunk. A flat table of 65,536 pointers is not used. The set of prefix heads at depth 16 is treated as one conceptual bit vector, cut into 16-bit bit-masks. Each bit-mask is summarised by a code word: a 10-bit maptable row plus a 6-bit offset. A base count is kept for every group of four code words. A small maptable of 4-bit offsets gives the position of a pointer inside its group. The pointer-array slot is the sum of the base count, the code-word offset and the maptable offset.

The four tables live in on-chip RAMs. They are filled through a single write port while no lookup is in flight. Lookups are fully pipelined. One key can enter every cycle, and each key comes back with its pointer, the pointer's type and index fields, and the key itself as a tag, a fixed four cycles later. A code word whose row value lies above the last maptable row is a direct entry. For a direct entry the code word is the pointer, and neither the maptable nor the pointer array is consulted.

Top module: `lpm_l1_lookup`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid` is low, whatever `in_valid` does.
- R2: Key bits [15:4] select the code word, key bits [15:6] select the base count, and key bits [3:0] select the maptable column.
- R3: A code word is split with the maptable row in bits [15:6] and the group offset in bits [5:0]. Row values 0 to 676 are ordinary rows.
- R4: For an ordinary row, the pointer-array slot is (base + offset + column entry) mod 2048. The 16-bit sum wraps. Column c of a maptable row sits at bits [4c+3:4c] of the row word.
- R5: A row value above 676 is a direct entry. The output pointer equals the code word, and maptable and pointer-array contents have no effect on it.
- R6: `out_type` equals pointer bits [15:14] (00 next hop, 01 chunk) and `out_index` equals pointer bits [13:0].
- R7: A key sampled with `in_valid` high on a rising edge appears on `out_tag`, with `out_valid` high, after the third following rising edge. That is a latency of four edges.
- R8: Keys offered on consecutive cycles are all accepted, and each yields exactly one result, in order.
- R9: A write with `wr_en` high stores into the table picked by `wr_sel` (0 code words, 1 base counts, 2 maptable rows, 3 pointers) at `wr_addr`. Maptable rows take all 64 bits of `wr_data`; the other tables take bits [15:0].
- R10: Writes are made only while no lookup is entering or in flight. Lookups issued after such writes see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A lookup key is offered this cycle |
| in_key | input | 16 | Upper 16 destination-address bits |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 2 | Table selected for the write |
| wr_addr | input | 12 | Entry address within the selected table |
| wr_data | input | 64 | Write data (maptable row, or low 16 bits) |
| out_valid | output | 1 | Result present |
| out_tag | output | 16 | Key the result belongs to |
| out_ptr | output | 16 | Resolved pointer |
| out_type | output | 2 | Pointer type field |
| out_index | output | 14 | Pointer index field |

## Verification
Each stage could hold a wrong value, such as a misrouted code-word field, a wrong column selection, a lost carry in the index sum or a direct flag that fails to follow its key. Any of these appears as a wrong `out_ptr` on the same key's result, exactly four edges after the key enters. A stage valid bit that is dropped or stuck shows up at the same point as a missing result, an extra result or a shifted `out_tag`. The bench keeps one expected record per key, so a single corrupted result is caught on the cycle it appears. The boundary rows 676 and 677, column 15 and a wrapping base sum are forced directly, because random tables reach them only rarely.

// File: rtl/lpm_l1_pkg.sv
// Package: shared constants and table-select codes for the first-level
// compressed prefix lookup. Assumes 16-bit keys and 16-bit pointers.
package lpm_l1_pkg;
    localparam int KEY_BITS     = 16;
    localparam int PTR_BITS     = 16;
    localparam int ROW_BITS     = 10;
    localparam int GOFF_BITS    = 6;
    localparam int MOFF_BITS    = 4;
    localparam int LAST_MAP_ROW = 676;

    // Table picked by the write port.
    typedef enum logic [1:0] {
        TS_CODE = 2'd0,
        TS_BASE = 2'd1,
        TS_MAP  = 2'd2,
        TS_PTR  = 2'd3
    } tbl_sel_e;

    // Pointer type field values.
    typedef enum logic [1:0] {
        PK_NEXT_HOP = 2'b00,
        PK_CHUNK    = 2'b01
    } ptr_kind_e;
endpackage

// File: rtl/lpm_ram.sv
// Module: lpm_ram
// Single-clock RAM with one write port and one registered read port.
// Assumes: the read data holds its value when no read is enabled; writes
// to addresses at or beyond DEPTH are dropped.
module lpm_ram #(
    parameter int W     = 16,
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Store write data into the addressed word.
    always_ff @(posedge clk) begin
        if (we && (32'(waddr) < DEPTH)) begin
            mem[waddr] <= wdata;
        end
    end

    // Register the read word one cycle after the address.
    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/lpm_slot_calc.sv
// Module: lpm_slot_calc
// Combinational stage: picks the column offset from a maptable row word
// and forms the pointer-array slot as base + group offset + column offset,
// wrapping in PTR_W bits and then keeping the low SLOT_W bits.
// Assumes the row word packs column c at bits [c*MOFF_W +: MOFF_W].
module lpm_slot_calc #(
    parameter int PTR_W  = 16,
    parameter int GOFF_W = 6,
    parameter int MOFF_W = 4,
    parameter int COL_W  = 4,
    parameter int SLOT_W = 11,
    localparam int ROW_WORD_W = (1 << COL_W) * MOFF_W
) (
    input  logic [ROW_WORD_W-1:0] row_word,
    input  logic [COL_W-1:0]      col,
    input  logic [PTR_W-1:0]      base,
    input  logic [GOFF_W-1:0]     goff,
    output logic [SLOT_W-1:0]     slot
);
    logic [MOFF_W-1:0] moff;
    logic [PTR_W-1:0]  sum;

    // Select the column entry and add the three terms.
    always_comb begin
        moff = row_word[int'(col) * MOFF_W +: MOFF_W];
        sum  = base + PTR_W'(goff) + PTR_W'(moff);
        slot = sum[SLOT_W-1:0];
    end
endmodule

// File: rtl/lpm_l1_lookup.sv
// Module: lpm_l1_lookup
// First-level compressed prefix lookup. Four pipeline stages:
//   S0 reads the code word and base count, S1 reads the maptable row,
//   S2 reads the pointer word, S3 registers the result.
// Direct entries (row above LAST_ROW) skip both later reads and return the
// code word. Assumes the write port is idle whenever a key is in flight.
module lpm_l1_lookup
    import lpm_l1_pkg::*;
#(
    parameter int KEY_W     = KEY_BITS,
    parameter int PTR_W     = PTR_BITS,
    parameter int CW_AW     = 12,
    parameter int BI_AW     = 10,
    parameter int ROW_W     = ROW_BITS,
    parameter int GOFF_W    = GOFF_BITS,
    parameter int MOFF_W    = MOFF_BITS,
    parameter int LAST_ROW  = LAST_MAP_ROW,
    parameter int PTR_DEPTH = 2048,
    localparam int COL_W    = KEY_W - CW_AW,
    localparam int MAP_W    = (1 << COL_W) * MOFF_W,
    localparam int MAP_ROWS = LAST_ROW + 1,
    localparam int MAP_AW   = $clog2(MAP_ROWS),
    localparam int SLOT_W   = $clog2(PTR_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [KEY_W-1:0] in_key,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CW_AW-1:0] wr_addr,
    input  logic [MAP_W-1:0] wr_data,
    output logic             out_valid,
    output logic [KEY_W-1:0] out_tag,
    output logic [PTR_W-1:0] out_ptr,
    output logic [1:0]       out_type,
    output logic [PTR_W-3:0] out_index
);
    // Stage valid bits and carried fields.
    logic             s1_v, s2_v, s3_v;
    logic [KEY_W-1:0] s1_key, s2_key, s3_key;
    logic             s2_direct, s3_direct;
    logic [PTR_W-1:0] s2_cw, s3_cw, s2_base;
    logic [GOFF_W-1:0] s2_goff;

    // RAM read data.
    logic [PTR_W-1:0] cw_q, base_q, ptr_q;
    logic [MAP_W-1:0] map_q;

    // S1 decode of the code word.
    logic [ROW_W-1:0]  s1_row;
    logic [GOFF_W-1:0] s1_goff;
    logic              s1_direct;
    logic              map_re;

    // S2 slot and S3 pointer choice.
    logic [SLOT_W-1:0] s2_slot;
    logic              ptr_re;
    logic [PTR_W-1:0]  s3_ptr;

    // Write-enable per table.
    logic we_code, we_base, we_map, we_ptr;

    // Decode the table select into per-RAM strobes.
    always_comb begin
        we_code = wr_en && (wr_sel == TS_CODE);
        we_base = wr_en && (wr_sel == TS_BASE);
        we_map  = wr_en && (wr_sel == TS_MAP);
        we_ptr  = wr_en && (wr_sel == TS_PTR);
    end

    lpm_ram #(.W(PTR_W), .DEPTH(1 << CW_AW)) u_code (
        .clk   (clk),
        .we    (we_code),
        .waddr (wr_addr),
        .wdata (wr_data[PTR_W-1:0]),
        .re    (in_valid),
        .raddr (in_key[KEY_W-1 -: CW_AW]),
        .rdata (cw_q)
    );

    lpm_ram #(.W(PTR_W), .DEPTH(1 << BI_AW)) u_base (
        .clk   (clk),
        .we    (we_base),
        .waddr (wr_addr[BI_AW-1:0]),
        .wdata (wr_data[PTR_W-1:0]),
        .re    (in_valid),
        .raddr (in_key[KEY_W-1 -: BI_AW]),
        .rdata (base_q)
    );

    // Split the code word and flag direct entries.
    always_comb begin
        s1_row    = cw_q[PTR_W-1 -: ROW_W];
        s1_goff   = cw_q[GOFF_W-1:0];
        s1_direct = (32'(s1_row) > LAST_ROW);
        map_re    = s1_v && !s1_direct;
    end

    lpm_ram #(.W(MAP_W), .DEPTH(MAP_ROWS)) u_map (
        .clk   (clk),
        .we    (we_map),
        .waddr (wr_addr[MAP_AW-1:0]),
        .wdata (wr_data),
        .re    (map_re),
        .raddr (s1_row[MAP_AW-1:0]),
        .rdata (map_q)
    );

    lpm_slot_calc #(
        .PTR_W  (PTR_W),
        .GOFF_W (GOFF_W),
        .MOFF_W (MOFF_W),
        .COL_W  (COL_W),
        .SLOT_W (SLOT_W)
    ) u_slot (
        .row_word (map_q),
        .col      (s2_key[COL_W-1:0]),
        .base     (s2_base),
        .goff     (s2_goff),
        .slot     (s2_slot)
    );

    // Pointer read only for ordinary rows.
    always_comb begin
        ptr_re = s2_v && !s2_direct;
    end

    lpm_ram #(.W(PTR_W), .DEPTH(PTR_DEPTH)) u_ptr (
        .clk   (clk),
        .we    (we_ptr),
        .waddr (wr_addr[SLOT_W-1:0]),
        .wdata (wr_data[PTR_W-1:0]),
        .re    (ptr_re),
        .raddr (s2_slot),
        .rdata (ptr_q)
    );

    // Choose the direct code word or the fetched pointer.
    always_comb begin
        s3_ptr = s3_direct ? s3_cw : ptr_q;
    end

    // Advance the stage valid bits; reset empties the pipe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v      <= 1'b0;
            s2_v      <= 1'b0;
            s3_v      <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            s1_v      <= in_valid;
            s2_v      <= s1_v;
            s3_v      <= s2_v;
            out_valid <= s3_v;
        end
    end

    // Carry key and decoded fields down the pipe.
    always_ff @(posedge clk) begin
        s1_key    <= in_key;
        s2_key    <= s1_key;
        s2_direct <= s1_direct;
        s2_cw     <= cw_q;
        s2_base   <= base_q;
        s2_goff   <= s1_goff;
        s3_key    <= s2_key;
        s3_direct <= s2_direct;
        s3_cw     <= s2_cw;
        out_tag   <= s3_key;
        out_ptr   <= s3_ptr;
    end

    // Expose the pointer's type and index fields.
    always_comb begin
        out_type  = out_ptr[PTR_W-1 -: 2];
        out_index = out_ptr[PTR_W-3:0];
    end
endmodule

// File: rtl/lpm_l1_lookup_chk.sv
// Module: lpm_l1_lookup_chk
// Checker bound to lpm_l1_lookup: watches reset behaviour, fixed latency,
// tag return and the no-write-in-flight rule. The latency is a constant 4.
module lpm_l1_lookup_chk #(
    parameter int KEY_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [KEY_W-1:0] in_key,
    input logic             wr_en,
    input logic             s1_v,
    input logic             s2_v,
    input logic             s3_v,
    input logic             out_valid,
    input logic [KEY_W-1:0] out_tag
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);

    // R7
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 4));

    // R7
    tag_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_tag == $past(in_key, 4)));

    // R8
    no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid, 4) && $past(rst_n, 4) && $past(rst_n, 3) &&
         $past(rst_n, 2) && $past(rst_n, 1)) |-> out_valid);

    // R10
    write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !(in_valid || s1_v || s2_v || s3_v));
endmodule

bind lpm_l1_lookup lpm_l1_lookup_chk #(.KEY_W(KEY_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_key    (in_key),
    .wr_en     (wr_en),
    .s1_v      (s1_v),
    .s2_v      (s2_v),
    .s3_v      (s3_v),
    .out_valid (out_valid),
    .out_tag   (out_tag)
);

// File: tb/lpm_l1_lookup_test.sv
// Bench: loads random tables through the write port, runs random and
// directed lookups, and compares each result with a model of the tables.
module lpm_l1_lookup_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_key = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [11:0] wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic        out_valid;
    logic [15:0] out_tag, out_ptr;
    logic [1:0]  out_type;
    logic [13:0] out_index;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [15:0] cw_m [4096];
    logic [15:0] bi_m [1024];
    logic [63:0] map_m [677];
    logic [15:0] ptr_m [2048];

    logic [15:0] key_q [$];
    logic [15:0] exp_q [$];
    int          cyc_q [$];
    int          n_issued = 0;
    int          n_seen = 0;

    lpm_l1_lookup uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_key(in_key),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
        .out_valid(out_valid), .out_tag(out_tag), .out_ptr(out_ptr),
        .out_type(out_type), .out_index(out_index)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Model of the lookup rules (R2..R5).
    function automatic logic [15:0] expect_ptr(input logic [15:0] k);
        logic [15:0] cw, sum;
        logic [9:0]  row;
        logic [3:0]  moff;
        cw  = cw_m[k[15:4]];
        row = cw[15:6];
        if (row > 10'd676) return cw;
        moff = map_m[row][k[3:0]*4 +: 4];
        sum  = bi_m[k[15:6]] + {10'd0, cw[5:0]} + {12'd0, moff};
        return ptr_m[sum[10:0]];
    endfunction

    task automatic tbl_write(input logic [1:0] sel, input int addr, input logic [63:0] d);
        @(negedge clk);
        in_valid = 1'b0;
        wr_en = 1'b1; wr_sel = sel; wr_addr = 12'(addr); wr_data = d;
        case (sel)
            2'd0: cw_m[addr] = d[15:0];
            2'd1: bi_m[addr] = d[15:0];
            2'd2: map_m[addr] = d;
            default: ptr_m[addr] = d[15:0];
        endcase
    endtask

    task automatic write_off();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(input logic [15:0] k);
        @(negedge clk);
        wr_en = 1'b0;
        in_valid = 1'b1; in_key = k;
        key_q.push_back(k);
        exp_q.push_back(expect_ptr(k));
        cyc_q.push_back(cyc);
        n_issued++;
    endtask

    task automatic drain();
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = 0; i < 20 && exp_q.size() != 0; i++) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    // Compare each result against its queued expectation.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            n_seen++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected result", 64'(out_tag), 64'hFFFF_FFFF);
            end else begin
                logic [15:0] k, e;
                int c;
                k = key_q.pop_front();
                e = exp_q.pop_front();
                c = cyc_q.pop_front();
                check(out_ptr == e,
                      (cw_m[k[15:4]][15:6] > 10'd676) ? "R5 direct pointer" : "R4 slot pointer",
                      64'(out_ptr), 64'(e));
                check(out_tag == k, "R7 tag", 64'(out_tag), 64'(k));
                check(cyc - c == 4, "R7 latency", 64'(cyc - c), 64'd4);
                check(out_type == e[15:14] && out_index == e[13:0], "R6 fields",
                      64'({out_type, out_index}), 64'(e));
            end
        end
    end

    // Watchdog: an over-long run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] k2_before;
        void'($urandom(32'd20231));
        // R1: reset holds the output low even with a key offered.
        in_valid = 1'b1; in_key = 16'h1234;
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R1 during reset", 64'(out_valid), 64'd0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 after reset", 64'(out_valid), 64'd0);

        // R9: fill every table through the write port.
        for (int i = 0; i < 4096; i++) tbl_write(2'd0, i, 64'($urandom()));
        for (int i = 0; i < 1024; i++) tbl_write(2'd1, i, 64'($urandom()));
        for (int i = 0; i < 677; i++)  tbl_write(2'd2, i, rnd64());
        for (int i = 0; i < 2048; i++) tbl_write(2'd3, i, 64'($urandom()));
        // R2 R3 R4: row 676, column 15, base sum that wraps past 16 bits.
        tbl_write(2'd0, 12'hABC, 64'({10'd676, 6'd63}));
        tbl_write(2'd1, 10'h2AF, 64'h0000_FFF0);
        tbl_write(2'd2, 676, 64'hF123_4567_89AB_CDE0);
        tbl_write(2'd3, 62, 64'h0000_4ABC);
        // R5: row 677 and row 1023 are direct.
        tbl_write(2'd0, 12'h123, 64'({10'd677, 6'd5}));
        tbl_write(2'd0, 12'h124, 64'h0000_FFFF);
        // R2: column 0 of row 676 against base 0.
        tbl_write(2'd0, 12'h010, 64'({10'd676, 6'd1}));
        tbl_write(2'd1, 10'h004, 64'h0000_0000);
        write_off();

        lookup(16'hABCF);
        lookup(16'h1230);
        lookup(16'h124A);
        lookup(16'h0100);
        drain();
        check(ptr_m[62] == 16'h4ABC && expect_ptr(16'hABCF) == 16'h4ABC,
              "R4 wrap model", 64'(expect_ptr(16'hABCF)), 64'h4ABC);

        // R8: random stream, mostly back to back.
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(3) == 0) begin
                @(negedge clk);
                in_valid = 1'b0;
            end else begin
                lookup(16'($urandom()));
            end
        end
        for (int i = 0; i < 60; i++) lookup(16'($urandom()));
        drain();
        check(n_seen == n_issued, "R8 result count", 64'(n_seen), 64'(n_issued));

        // R5 R9 R10: rewrite pointers and maptable rows between lookups.
        k2_before = expect_ptr(16'h1230);
        for (int i = 0; i < 2048; i++) tbl_write(2'd3, i, 64'($urandom()));
        tbl_write(2'd3, 62, 64'h0000_7001);
        for (int i = 0; i < 677; i++) tbl_write(2'd2, i, rnd64());
        tbl_write(2'd2, 676, 64'hF000_0000_0000_0000);
        write_off();
        check(expect_ptr(16'h1230) == k2_before, "R5 model unchanged",
              64'(expect_ptr(16'h1230)), 64'(k2_before));
        lookup(16'h1230);
        lookup(16'hABCF);
        for (int i = 0; i < 200; i++) lookup(16'($urandom()));
        drain();
        check(n_seen == n_issued, "R10 results after rewrite", 64'(n_seen), 64'(n_issued));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule